// File: doc/BRIEF.md
# Periodic System Tick Timer

The block is a periodic tick source for a processor subsystem. Its core is a 24-bit down-counter. Each time the counter is already at zero when a count step arrives, it loads itself again from a programmable period register. Every step that takes the counter from one to zero raises a sticky wrap flag. When the interrupt enable is set, that same step also sends a single-cycle pulse on the interrupt line. The tick period is therefore the period value plus one count steps.

Count steps come from one of two sources. One is the bus clock itself. The other is a one-cycle enable pulse that a 3-bit prescaler produces every eighth bus clock. After reset the divided source is selected.

A read-only calibration word holds a fixed count of 9000. This is the number of divided steps in one millisecond at a 72 MHz bus clock. Software reads it to work out a period value. The word has no influence on counting.

Software reaches four word registers over a simple synchronous bus, selected by `bus_addr`:

| `bus_addr` | Register |
|---|---|
| 0 | control |
| 1 | period |
| 2 | current count |
| 3 | calibration |

A request is presented for one cycle with `bus_sel` high and `bus_wr` choosing write or read. Read data is registered and appears on `bus_rdata` in the cycle after the request. It then holds until the next read.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, the control, period and current-count registers all read 0. The calibration register reads 9000 and `tick_irq` is low.
- R2: With the run bit (control bit 0) set and the fast bit (control bit 2) set, the counter steps once per bus clock. It decrements by one per step. A step taken at zero reloads the period value, so ticks repeat every period+1 clocks.
- R3: With the run bit set and the fast bit clear, the counter steps once every 8 bus clocks, and ticks repeat every 8*(period+1) clocks.
- R4: A step from 1 to 0 sets the wrap flag, which reads as control bit 16. A read of the control register returns the flag and then clears it. A second read returns 0 in bit 16.
- R5: With the interrupt-enable bit (control bit 1) set, `tick_irq` is high for exactly one cycle per 1-to-0 step, in the cycle the count shows 0. With that bit clear, `tick_irq` stays low while the flag still sets.
- R6: Any write to the current-count register (address 2) sets the count to 0 and clears the wrap flag. The next step reloads the counter without a tick, so the first tick comes period+1 steps after the counter starts.
- R7: A period value of 0 leaves the counter at 0 after its next reload, and no further ticks occur.
- R8: Writes to the calibration register (address 3) are ignored. It always reads 9000, and its value has no effect on the tick interval.
- R9: Unused bits read as 0. The period register keeps only bits 23:0, and the control register returns only bits 0, 1, 2 and 16.
- R10: With the run bit clear, the current count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word register select (0 control, 1 period, 2 current, 3 calibration) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
On every cycle the assertions check the following:
- the counter decrements by exactly one per step;
- the counter holds when no step or clear is present;
- a current-count write leaves zero behind with no tick;
- the interrupt is a single-cycle pulse seen only at a zero count;
- prescaler pulses never come back to back;
- the calibration word is the value returned.

Some properties cannot be seen in one cycle, and only the bench scenarios can show them:
- the tick interval in clocks for both step sources;
- the read-clears behaviour of the flag;
- the stop after a zero period;
- the fact that calibration writes leave the interval unchanged.

The bench shows these by sweeping the period values and read spacings and comparing against arithmetic expectations.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_NOW    = 2'd2,
    REG_CAL    = 2'd3
  } reg_sel_e;

  localparam int BIT_RUN  = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_FAST = 2;
  localparam int BIT_WRAP = 16;

  typedef struct packed {
    logic fast;
    logic ie;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  output logic pulse_o
);
  localparam logic [DIV_LOG2-1:0] LAST = '1;

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_o <= (cnt_q == LAST - 1'b1);
    end
  end

  // R3: divided enable is a single-cycle pulse, never two in a row
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R3: pulse coincides with counter wrapping back to zero
  a_r3_pulse_phase: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (cnt_q == LAST));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             ie_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             wrap_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o  <= '0;
      wrap_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      wrap_o <= 1'b0;
      irq_o  <= 1'b0;
      if (clr_i) begin
        cur_o <= '0;
      end else if (step_i) begin
        if (cur_o == '0) begin
          cur_o <= reload_i;
        end else begin
          cur_o <= cur_o - ONE;
          if (cur_o == ONE) begin
            wrap_o <= 1'b1;
            irq_o  <= ie_i;
          end
        end
      end
    end
  end

  // R2: a step from a nonzero count lowers it by exactly one
  a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clr_i && cur_o != '0) |=> (cur_o == $past(cur_o) - ONE));
  // R10: no step and no clear leaves the count untouched
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !clr_i) |=> $stable(cur_o));
  // R6: a clear leaves zero behind and raises no tick
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cur_o == '0 && !irq_o && !wrap_o));
  // R5: interrupt only shows together with a zero count
  a_r5_irq_at_zero: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (cur_o == '0 && wrap_o));
  // R5: interrupt lasts a single cycle
  a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import systick_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int CAL_TICKS = 9000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cur_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              clr_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int PAD_W = BUS_W - CNT_W;
  localparam logic [BUS_W-1:0] CAL_WORD = BUS_W'(CAL_TICKS);

  logic wr_ctrl, wr_period, rd_req, rd_ctrl;
  logic flag_q;
  logic [BUS_W-1:0] rd_mux;

  assign wr_ctrl   = sel_i && wr_i && (addr_i == REG_CTRL);
  assign wr_period = sel_i && wr_i && (addr_i == REG_PERIOD);
  assign clr_o     = sel_i && wr_i && (addr_i == REG_NOW);
  assign rd_req    = sel_i && !wr_i;
  assign rd_ctrl   = rd_req && (addr_i == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o   <= '0;
      reload_o <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_o.run  <= wdata_i[BIT_RUN];
        ctrl_o.ie   <= wdata_i[BIT_IE];
        ctrl_o.fast <= wdata_i[BIT_FAST];
      end
      if (wr_period) reload_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (clr_o)   flag_q <= 1'b0;
    else if (wrap_i)  flag_q <= 1'b1;
    else if (rd_ctrl) flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rd_mux[BIT_RUN]  = ctrl_o.run;
        rd_mux[BIT_IE]   = ctrl_o.ie;
        rd_mux[BIT_FAST] = ctrl_o.fast;
        rd_mux[BIT_WRAP] = flag_q;
      end
      REG_PERIOD: rd_mux = {{PAD_W{1'b0}}, reload_o};
      REG_NOW:    rd_mux = {{PAD_W{1'b0}}, cur_i};
      REG_CAL:    rd_mux = CAL_WORD;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_o <= '0;
    else if (rd_req) rdata_o <= rd_mux;
  end

  // R8: calibration reads always return the fixed word
  a_r8_cal_read: assert property (@(posedge clk) disable iff (rst)
    (rd_req && addr_i == REG_CAL) |=> (rdata_o == CAL_WORD));
  // R4: a control read with no competing set clears the flag
  a_r4_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !wrap_i) |=> !flag_q);
  // R9: unused control bits read as zero
  a_r9_ctrl_unused: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl |=> (rdata_o[BUS_W-1:BIT_WRAP+1] == '0 && rdata_o[BIT_WRAP-1:BIT_FAST+1] == '0));
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import systick_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int DIV_LOG2  = 3,
  parameter int CAL_TICKS = 9000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tick_irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cur;
  logic             clr, wrap, div_pulse, step;

  tick_regs #(.CNT_W(CNT_W), .CAL_TICKS(CAL_TICKS)) u_regs (
    .clk(clk), .rst(rst), .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .cur_i(cur), .wrap_i(wrap), .ctrl_o(ctrl),
    .reload_o(reload), .clr_o(clr), .rdata_o(bus_rdata)
  );

  tick_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst(rst), .pulse_o(div_pulse)
  );

  assign step = ctrl.run && (ctrl.fast || div_pulse);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .clr_i(clr), .ie_i(ctrl.ie),
    .reload_i(reload), .cur_o(cur), .wrap_o(wrap), .irq_o(tick_irq)
  );

  // R5: no interrupt while the interrupt enable was clear at the step
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> $past(ctrl.ie));
  // R10: a stopped timer never ticks
  a_r10_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
    !ctrl.run |=> !wrap);
endmodule

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_PER = 2'd1, A_NOW = 2'd2, A_CAL = 2'd3;
  localparam int CAL = 9000;

  always #10 clk = ~clk;

  sys_tick_timer u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // cycles from the current negedge until tick_irq seen, bounded
  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (tick_irq) return;
    end
    n = -1;
  endtask

  task automatic restart(input logic [23:0] per, input logic [31:0] ctl);
    wr(A_CTRL, 32'h0);
    wr(A_PER, {8'h0, per});
    wr(A_NOW, 32'h0);
    wr(A_CTRL, ctl);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [31:0] d, d2;
    int n, n2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, tick_irq}, 32'h0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_PER, d);  chk("R1 period", d, 32'h0);
    rd(A_NOW, d);  chk("R1 now", d, 32'h0);
    rd(A_CAL, d);  chk("R1 cal", d, CAL);

    // R9 width masking
    wr(A_PER, 32'hFFFF_FFFF);
    rd(A_PER, d); chk("R9 period mask", d, 32'h00FF_FFFF);
    wr(A_NOW, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R9 ctrl mask", d, 32'h0000_0007);

    // R2 decrement per clock, sweep of read spacing
    for (int w = 0; w < 10; w++) begin
      rd(A_NOW, d);
      repeat (w) @(negedge clk);
      rd(A_NOW, d2);
      chk("R2 step per clock", d - d2, 32'(w + 2));
    end

    // R3 divided steps: spacing multiple of 8
    wr(A_CTRL, 32'h1);
    for (int m = 1; m <= 4; m++) begin
      rd(A_NOW, d);
      repeat (8 * m - 2) @(negedge clk);
      rd(A_NOW, d2);
      chk("R3 step per 8 clocks", d - d2, 32'(m));
    end

    // R10 hold when stopped
    wr(A_CTRL, 32'h0);
    rd(A_NOW, d);
    repeat (20) @(negedge clk);
    rd(A_NOW, d2);
    chk("R10 hold", d2, d);

    // R6 first tick after clear, sweep of period, fast source
    for (int p = 1; p <= 6; p++) begin
      restart(24'(p), 32'h7);
      wait_irq(100, n);
      chk("R6 first tick latency", 32'(n), 32'(p + 1));
      @(negedge clk);
      chk("R5 irq one cycle", {31'b0, tick_irq}, 32'h0);
      wait_irq(100, n2);
      chk("R2 tick interval", 32'(n2 + 1), 32'(p + 1));
    end

    // R8 calibration writes ignored and no effect on interval
    wr(A_CAL, 32'h0000_1234);
    rd(A_CAL, d); chk("R8 cal read-only", d, CAL);
    restart(24'd4, 32'h7);
    wait_irq(100, n);
    wait_irq(100, n2);
    chk("R8 interval unaffected", 32'(n2), 32'd5);

    // R3 tick interval with divided source
    for (int p = 1; p <= 3; p++) begin
      restart(24'(p), 32'h3);
      wait_irq(200, n);
      wait_irq(200, n2);
      chk("R3 tick interval", 32'(n2), 32'(8 * (p + 1)));
    end

    // R4 flag set and read-clear; R5 no irq with ie clear
    restart(24'd5, 32'h5);
    wait_irq(40, n);
    chk("R5 no irq when disabled", 32'(n), 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); chk("R4 flag set", d, 32'h0001_0000);
    rd(A_CTRL, d); chk("R4 flag cleared", d, 32'h0);

    // R6 current write clears flag
    restart(24'd3, 32'h5);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h0);
    wr(A_NOW, 32'h0000_00AB);
    rd(A_NOW, d);  chk("R6 now cleared", d, 32'h0);
    rd(A_CTRL, d); chk("R6 flag cleared", d, 32'h0);

    // R7 zero period stops ticking
    restart(24'd3, 32'h7);
    wait_irq(20, n);
    wr(A_PER, 32'h0);
    repeat (10) @(negedge clk);
    wait_irq(60, n);
    chk("R7 no further ticks", 32'(n), 32'hFFFF_FFFF);
    rd(A_NOW, d); chk("R7 parked at zero", d, 32'h0);

    finish_up();
  end
endmodule